// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block performs interrupt entry for a small 32-bit processor core. It watches two sources: a group of level-active external request lines, merged into one maskable condition, and a synchronous strobe from the fetch unit that reports an instruction-fetch access fault. When it takes an interrupt it does all of the entry work at one clock edge. It saves a return address and the old machine state into two save registers. It rewrites the machine state register by fixed per-bit rules and, for a fetch fault, rewrites a syndrome register. It also forms the handler address from a 16-bit vector prefix and a fixed offset for each cause.

The fetch unit receives a one-cycle taken pulse, a cause code and the handler address, and uses them to redirect. The handler reaches the machine state, syndrome and prefix registers through simple write strobes. For example, it sets the external-enable bit again once it has stored the save registers.

Top module: `intr_entry_seq`

## Requirements
- R1: Each external request line alone, when held high while the external-enable bit (state bit 15) is 1 and no fetch fault is present, causes an external interrupt at the next clock edge.
- R2: While state bit 15 is 0, external requests are not taken and leave every output unchanged.
- R3: At the edge that takes an external interrupt, the return save register loads `nextPc` and the state save register loads the state value from before that edge.
- R4: Taking an interrupt clears state bit 15, so a request held high is not taken a second time until software sets the bit again.
- R5: The handler address is {prefix[15:0], 16'h0500} for an external interrupt and {prefix[15:0], 16'h0400} for a fetch fault, using the prefix value from before the edge.
- R6: A fetch fault is taken whatever the value of bit 15, and the return save register loads `curPc`, the address of the faulting instruction.
- R7: On any entry the new state keeps bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) and clears every other bit.
- R8: On a fetch fault the syndrome becomes: bit 22 set only if `faultUser` is 1 and `faultZone` is 2'b00, bit 31 kept, all other bits 0. An external interrupt does not change the syndrome.
- R9: When a fetch fault and an enabled external request arrive in the same cycle, the fetch fault is taken, and the external request is then masked by the cleared bit 15.
- R10: `takenQ` is 1 for exactly the cycle after a taking edge, and `causeQ` then reads 1 for external or 2 for fetch fault. Otherwise `causeQ` reads 0.
- R11: While `rstN` is 0, all save, state, syndrome and address outputs read 0 and nothing is taken, even with a fault or request present.
- R12: A write strobe updates its register at the next edge. A state write in the same cycle as any entry, or a syndrome write in the same cycle as a fetch fault, is discarded in favour of the entry rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extReq | input | NUM_REQ | Level-active external request lines |
| fetchFault | input | 1 | Instruction-fetch access fault in this cycle |
| faultUser | input | 1 | The faulting fetch was made in user mode |
| faultZone | input | 2 | Zone protection code of the faulting fetch |
| curPc | input | XLEN | Address of the current (faulting) instruction |
| nextPc | input | XLEN | Address of the next sequential instruction |
| stateWrEn | input | 1 | Write strobe for the machine state register |
| stateWrData | input | XLEN | Machine state write value |
| synWrEn | input | 1 | Write strobe for the syndrome register |
| synWrData | input | XLEN | Syndrome write value |
| prefixWrEn | input | 1 | Write strobe for the vector prefix |
| prefixWrData | input | XLEN/2 | Vector prefix write value |
| saveRetQ | output | XLEN | Saved return address |
| saveStateQ | output | XLEN | Saved machine state |
| stateQ | output | XLEN | Machine state register |
| syndromeQ | output | XLEN | Syndrome register |
| vectorQ | output | XLEN | Handler address for the redirect |
| takenQ | output | 1 | One-cycle interrupt-taken pulse |
| causeQ | output | 2 | Cause code: 0 none, 1 external, 2 fetch fault |

## Verification
The bench builds the block with three request lines and the default 32-bit width. Three lines are enough to walk each line of the OR on its own and still keep the random mix dense in requests. The 32-bit width puts the 16-bit prefix/offset split and the fixed bit positions (15, 17, 12, 9, 22, 31) at their real places, so the handler address and the per-bit rewrite rules can be checked against literal values. Random state writes switch the enable bit often, so fault/request collisions, held requests after entry, and writes that lose to an entry all happen many times.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

  // Machine state register bit map (32-bit layout)
  localparam int ST_DATA_XLATE = 4;
  localparam int ST_INSTR_XLATE = 5;
  localparam int ST_AUX_EXC_EN = 7;
  localparam int ST_FP_EXC1 = 8;
  localparam int ST_DBG_EN = 9;
  localparam int ST_DBG_WAIT_EN = 10;
  localparam int ST_FP_EXC0 = 11;
  localparam int ST_MCHK_EN = 12;
  localparam int ST_FP_AVAIL = 13;
  localparam int ST_USER_MODE = 14;
  localparam int ST_EXT_EN = 15;
  localparam int ST_AUX_EN = 16;
  localparam int ST_CRIT_EN = 17;
  localparam int ST_WAIT_EN = 18;

  // Syndrome register bit map
  localparam int SYN_ZONE_FAULT = 22;
  localparam int SYN_MCHK_INSTR = 31;

  localparam int STATE_W = 32;

  // Bits that survive interrupt entry
  localparam logic [STATE_W-1:0] STATE_KEEP_MASK =
      (STATE_W'(1) << ST_CRIT_EN) | (STATE_W'(1) << ST_MCHK_EN) | (STATE_W'(1) << ST_DBG_EN);

  // Syndrome bits that survive a fetch fault
  localparam logic [STATE_W-1:0] SYN_KEEP_MASK = STATE_W'(1) << SYN_MCHK_INSTR;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_EXT    = 2'd1,
    CAUSE_IFETCH = 2'd2
  } cause_e;

  typedef struct packed {
    logic takeFault;
    logic takeExt;
    logic wrState;
    logic wrSyn;
    logic wrPrefix;
  } strobe_t;

endpackage

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] extReq,
  input  logic               extEnable,
  input  logic               fetchFault,
  input  logic               stateWrEn,
  input  logic               synWrEn,
  input  logic               prefixWrEn,
  output strobe_t            strb,
  output logic               takenQ,
  output cause_e             causeQ
);

  logic anyReq;
  logic takeAny;
  cause_e causeNext;

  // merge the request lines one by one
  logic [NUM_REQ:0] reqChain;
  assign reqChain[0] = 1'b0;
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req_or
    assign reqChain[g+1] = reqChain[g] | extReq[g];
  end
  assign anyReq = reqChain[NUM_REQ];

  always_comb begin
    strb = '0;
    if (rstN) begin
      strb.takeFault = fetchFault;
      strb.takeExt   = !fetchFault && anyReq && extEnable;
      strb.wrPrefix  = prefixWrEn;
    end
    takeAny      = strb.takeFault | strb.takeExt;
    strb.wrState = rstN && stateWrEn && !takeAny;
    strb.wrSyn   = rstN && synWrEn && !strb.takeFault;
    if (strb.takeFault)    causeNext = CAUSE_IFETCH;
    else if (strb.takeExt) causeNext = CAUSE_EXT;
    else                   causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takenQ <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      takenQ <= takeAny;
      causeQ <= causeNext;
    end
  end

endmodule

// File: rtl/intr_entry_dp.sv
module intr_entry_dp
  import intr_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int EXT_OFFSET = 16'h0500,
  parameter int FAULT_OFFSET = 16'h0400
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic            faultUser,
  input  logic [1:0]      faultZone,
  input  logic [XLEN-1:0] stateWrData,
  input  logic [XLEN-1:0] synWrData,
  input  logic [XLEN/2-1:0] prefixWrData,
  output logic            extEnable,
  output logic [XLEN-1:0] saveRetQ,
  output logic [XLEN-1:0] saveStateQ,
  output logic [XLEN-1:0] stateQ,
  output logic [XLEN-1:0] syndromeQ,
  output logic [XLEN-1:0] vectorQ
);

  localparam int HALF = XLEN / 2;
  localparam logic [HALF-1:0] EXT_OFS = HALF'(EXT_OFFSET);
  localparam logic [HALF-1:0] FLT_OFS = HALF'(FAULT_OFFSET);

  logic [HALF-1:0] prefixQ;
  logic [XLEN-1:0] entryState;
  logic [XLEN-1:0] faultSyn;
  logic            takeAny;
  logic            zoneHit;

  assign takeAny   = strb.takeFault | strb.takeExt;
  assign extEnable = stateQ[ST_EXT_EN];
  assign zoneHit   = faultUser && (faultZone == 2'b00);

  // per-bit rewrite of the state on entry
  for (genvar b = 0; b < XLEN; b++) begin : g_entry_bits
    if (b < STATE_W && STATE_KEEP_MASK[b % STATE_W]) begin : g_keep
      assign entryState[b] = stateQ[b];
    end else begin : g_clear
      assign entryState[b] = 1'b0;
    end
  end

  always_comb begin
    faultSyn = '0;
    faultSyn[SYN_MCHK_INSTR] = syndromeQ[SYN_MCHK_INSTR];
    faultSyn[SYN_ZONE_FAULT] = zoneHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saveRetQ   <= '0;
      saveStateQ <= '0;
      stateQ     <= '0;
      syndromeQ  <= '0;
      vectorQ    <= '0;
      prefixQ    <= '0;
    end else begin
      if (takeAny) begin
        saveStateQ <= stateQ;
        stateQ     <= entryState;
        saveRetQ   <= strb.takeFault ? curPc : nextPc;
        vectorQ    <= {prefixQ, strb.takeFault ? FLT_OFS : EXT_OFS};
      end else if (strb.wrState) begin
        stateQ <= stateWrData;
      end
      if (strb.takeFault)  syndromeQ <= faultSyn;
      else if (strb.wrSyn) syndromeQ <= synWrData;
      if (strb.wrPrefix)   prefixQ   <= prefixWrData;
    end
  end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] extReq,
  input  logic               fetchFault,
  input  logic               faultUser,
  input  logic [1:0]         faultZone,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    nextPc,
  input  logic               stateWrEn,
  input  logic [XLEN-1:0]    stateWrData,
  input  logic               synWrEn,
  input  logic [XLEN-1:0]    synWrData,
  input  logic               prefixWrEn,
  input  logic [XLEN/2-1:0]  prefixWrData,
  output logic [XLEN-1:0]    saveRetQ,
  output logic [XLEN-1:0]    saveStateQ,
  output logic [XLEN-1:0]    stateQ,
  output logic [XLEN-1:0]    syndromeQ,
  output logic [XLEN-1:0]    vectorQ,
  output logic               takenQ,
  output logic [1:0]         causeQ
);

  strobe_t strb;
  logic    extEnable;
  cause_e  causeInt;

  intr_entry_ctrl #(.NUM_REQ(NUM_REQ)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .extReq     (extReq),
    .extEnable  (extEnable),
    .fetchFault (fetchFault),
    .stateWrEn  (stateWrEn),
    .synWrEn    (synWrEn),
    .prefixWrEn (prefixWrEn),
    .strb       (strb),
    .takenQ     (takenQ),
    .causeQ     (causeInt)
  );

  assign causeQ = causeInt;

  intr_entry_dp #(.XLEN(XLEN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .curPc        (curPc),
    .nextPc       (nextPc),
    .faultUser    (faultUser),
    .faultZone    (faultZone),
    .stateWrData  (stateWrData),
    .synWrData    (synWrData),
    .prefixWrData (prefixWrData),
    .extEnable    (extEnable),
    .saveRetQ     (saveRetQ),
    .saveStateQ   (saveStateQ),
    .stateQ       (stateQ),
    .syndromeQ    (syndromeQ),
    .vectorQ      (vectorQ)
  );

endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk
  import intr_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] extReq,
  input logic               fetchFault,
  input logic [XLEN-1:0]    stateQ,
  input logic [XLEN-1:0]    saveStateQ,
  input logic [XLEN-1:0]    vectorQ,
  input logic               takenQ,
  input logic [1:0]         causeQ
);

  a_r1_enabled_request_taken: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(|extReq) && $past(stateQ[ST_EXT_EN]) && !$past(fetchFault))
      |-> (takenQ && causeQ == CAUSE_EXT));

  a_r2_ext_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && takenQ && causeQ == CAUSE_EXT) |-> $past(stateQ[ST_EXT_EN]));

  a_r3_state_saved: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && takenQ) |-> saveStateQ == $past(stateQ));

  a_r4_enable_cleared: assert property (@(posedge clk) disable iff (!rstN)
    takenQ |-> !stateQ[ST_EXT_EN]);

  a_r5_vector_offset: assert property (@(posedge clk) disable iff (!rstN)
    takenQ |-> vectorQ[15:0] == ((causeQ == CAUSE_EXT) ? 16'h0500 : 16'h0400));

  a_r7_kept_bits: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && takenQ) |-> (stateQ & STATE_KEEP_MASK) == ($past(stateQ) & STATE_KEEP_MASK));

  a_r9_fault_first: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fetchFault)) |-> (takenQ && causeQ == CAUSE_IFETCH));

  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    takenQ == (causeQ != CAUSE_NONE));

endmodule

bind intr_entry_seq intr_entry_chk #(.XLEN(XLEN), .NUM_REQ(NUM_REQ)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .extReq     (extReq),
  .fetchFault (fetchFault),
  .stateQ     (stateQ),
  .saveStateQ (saveStateQ),
  .vectorQ    (vectorQ),
  .takenQ     (takenQ),
  .causeQ     (causeQ)
);

// File: tb/intr_entry_seq_tb_top.sv
`timescale 1ns/1ps
module intr_entry_seq_tb_top;

  localparam int XLEN = 32;
  localparam int NREQ = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NREQ-1:0] extReq = '0;
  logic fetchFault = 1'b0, faultUser = 1'b0;
  logic [1:0] faultZone = 2'b00;
  logic [XLEN-1:0] curPc = '0, nextPc = '0, stateWrData = '0, synWrData = '0;
  logic stateWrEn = 1'b0, synWrEn = 1'b0, prefixWrEn = 1'b0;
  logic [15:0] prefixWrData = '0;
  logic [XLEN-1:0] saveRetQ, saveStateQ, stateQ, syndromeQ, vectorQ;
  logic takenQ;
  logic [1:0] causeQ;

  always #2 clk = ~clk;

  intr_entry_seq #(.XLEN(XLEN), .NUM_REQ(NREQ)) dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] mState = 0, mSyn = 0, mRet = 0, mSaved = 0, mVec = 0;
  logic [15:0] mPrefix = 0;
  bit mTaken = 0;
  int mCause = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!rstN) begin
      mState = 0; mSyn = 0; mRet = 0; mSaved = 0; mVec = 0; mPrefix = 0; mTaken = 0; mCause = 0;
    end else begin
      bit reqSeen = 0;
      bit doFault = fetchFault;
      bit doExt;
      for (int i = 0; i < NREQ; i++) if (extReq[i]) reqSeen = 1;
      doExt = !doFault && reqSeen && mState[15];
      if (doFault || doExt) begin
        logic [31:0] ns = 0;
        mSaved = mState;
        mRet = doFault ? curPc : nextPc;
        mVec = {mPrefix, doFault ? 16'h0400 : 16'h0500};
        foreach (ns[k]) if (k == 17 || k == 12 || k == 9) ns[k] = mState[k];
        mState = ns;
        if (doFault) begin
          logic [31:0] sy = 0;
          sy[31] = mSyn[31];
          sy[22] = faultUser && faultZone == 2'b00;
          mSyn = sy;
        end else if (synWrEn) mSyn = synWrData;
        mTaken = 1; mCause = doFault ? 2 : 1;
      end else begin
        if (stateWrEn) mState = stateWrData;
        if (synWrEn) mSyn = synWrData;
        mTaken = 0; mCause = 0;
      end
      if (prefixWrEn) mPrefix = prefixWrData;
    end
  endtask

  // one clock: model follows the edge, then every output is compared
  task automatic cycle();
    @(posedge clk);
    model_step();
    #1;
    chk("R3/R6 saveRet", saveRetQ, mRet);
    chk("R3 saveState", saveStateQ, mSaved);
    chk("R7/R12 state", stateQ, mState);
    chk("R8/R12 syndrome", syndromeQ, mSyn);
    chk("R5 vector", vectorQ, mVec);
    chk("R10 taken", 32'(takenQ), 32'(mTaken));
    chk("R10 cause", 32'(causeQ), 32'(mCause));
  endtask

  task automatic quiet();
    extReq = '0; fetchFault = 0; stateWrEn = 0; synWrEn = 0; prefixWrEn = 0;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset holds everything at zero, even with a fault present
    fetchFault = 1; extReq = '1;
    repeat (3) cycle();
    chk("R11 reset taken", 32'(takenQ), 0);
    chk("R11 reset state", stateQ | saveRetQ | syndromeQ | vectorQ, 0);
    quiet();
    @(negedge clk); rstN = 1;
    cycle();

    // R12: writes land at the next edge
    prefixWrEn = 1; prefixWrData = 16'hABCD;
    stateWrEn = 1; stateWrData = 32'hFFFF_FFFF;
    cycle(); quiet();
    chk("R12 state write", stateQ, 32'hFFFF_FFFF);

    // R1/R3/R5/R7: line 0 takes an external interrupt
    extReq = 3'b001; nextPc = 32'h0000_1004; curPc = 32'h0000_1000;
    cycle();
    chk("R1 taken line0", 32'(takenQ), 1);
    chk("R10 cause ext", 32'(causeQ), 1);
    chk("R3 next pc", saveRetQ, 32'h0000_1004);
    chk("R3 old state", saveStateQ, 32'hFFFF_FFFF);
    chk("R5 ext vector", vectorQ, 32'hABCD_0500);
    chk("R7 rewritten state", stateQ, 32'h0002_1200);

    // R4/R2: held request is not taken again
    cycle(); cycle();
    chk("R4 no retake", 32'(takenQ), 0);
    chk("R2 vector unchanged", vectorQ, 32'hABCD_0500);

    // R1 line 2 after enable is restored
    extReq = 3'b100; stateWrEn = 1; stateWrData = 32'h0000_8000; nextPc = 32'h0000_2000;
    cycle(); stateWrEn = 0;
    chk("R2 masked during write cycle", 32'(takenQ), 0);
    cycle(); quiet();
    chk("R1 taken line2", 32'(takenQ), 1);
    chk("R3 next pc line2", saveRetQ, 32'h0000_2000);
    cycle();

    // R6/R8: user-mode zone 00 fault, syndrome preset to all ones
    synWrEn = 1; synWrData = 32'hFFFF_FFFF;
    cycle(); quiet();
    fetchFault = 1; faultUser = 1; faultZone = 2'b00; curPc = 32'h0000_3000; nextPc = 32'h0000_3004;
    cycle(); quiet();
    chk("R6 fault pc", saveRetQ, 32'h0000_3000);
    chk("R8 syndrome zone", syndromeQ, 32'h8040_0000);
    chk("R5 fault vector", vectorQ, 32'hABCD_0400);
    chk("R10 cause fault", 32'(causeQ), 2);

    // R9: fault and enabled request together, plus R12 state write loses
    stateWrEn = 1; stateWrData = 32'h0000_8000;
    cycle(); quiet();
    fetchFault = 1; faultUser = 0; extReq = 3'b010; stateWrEn = 1; stateWrData = 32'hFFFF_FFFF;
    curPc = 32'h0000_4000;
    cycle(); fetchFault = 0; stateWrEn = 0;
    chk("R9 fault first", 32'(causeQ), 2);
    chk("R8 no zone when supervisor", syndromeQ, 32'h8000_0000);
    chk("R12 write discarded", stateQ, 32'h0);
    cycle();
    chk("R9 ext masked after fault", 32'(takenQ), 0);
    quiet();

    // random mix checked against the model every clock
    for (int n = 0; n < 3000; n++) begin
      extReq = NREQ'($urandom);
      fetchFault = ($urandom % 8) == 0;
      faultUser = $urandom; faultZone = $urandom;
      curPc = $urandom; nextPc = $urandom;
      stateWrEn = ($urandom % 3) == 0; stateWrData = $urandom;
      synWrEn = ($urandom % 5) == 0; synWrData = $urandom;
      prefixWrEn = ($urandom % 9) == 0; prefixWrData = $urandom;
      cycle();
    end
    quiet();
    cycle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule